// File: doc/BRIEF.md
# Reset Pulse Stretcher with Source Capture

This block gathers reset requests from a set of single-cycle event strobes and from the system reset line itself, and drives that active-low, open-drain line low for at least a programmed minimum time. Two lengths exist, short and long, counted in ticks of a prescaler derived from the system clock. A length-control bit written by software picks between them. The operating mode can force that bit to the long setting, so a pulse that software shortened by mistake is long again on the next attempt.

For every reset it starts, the block stores a 4-bit code naming the event that caused it, so software can read the cause after the restart. A falling edge on the reset line caused from outside counts as its own event. The block masks the line's low level while it drives the line itself. Its edge detector re-arms only after the line has been seen high for two consecutive cycles.

A controller FSM has three states. `ST_ASSERT` drives the line low and counts ticks. `ST_RELEASE` lets the line go and waits until the synchronised line reads high. `ST_IDLE` waits for the next event. The transitions are:
- any reset request in any state goes to `ST_ASSERT`;
- the last tick of the stretch in `ST_ASSERT` goes to `ST_RELEASE`;
- a high line in `ST_RELEASE` goes to `ST_IDLE`.

Reset places the FSM in `ST_ASSERT` with the short length loaded, which produces the power-on pulse.

Top module: `rst_pulse_stretcher`

## Requirements
- R1: After `rst_ni` is released, `pin_drive_o` stays high for exactly SHORT_TICKS×(CLK_FREQ_HZ/TICK_FREQ_HZ) cycles, counted from the release. During that pulse `src_code_o` is 0 (power-on) and `len_long_o` is 0.
- R2: A non-zero `event_i` sampled at a clock edge makes `pin_drive_o` high in the following cycle. This holds in every state.
- R3: With the length bit clear when a pulse starts, `pin_drive_o` stays high for SHORT_TICKS×cycles-per-tick cycles.
- R4: With the length bit set when a pulse starts, `pin_drive_o` stays high for LONG_TICKS×cycles-per-tick cycles.
- R5: While `mode_i` is 4 (restart) or 5 (fail-safe), the length bit becomes 1 in the next cycle and stays 1 whatever `cfg_wr_i`/`cfg_long_i` do. After the mode leaves those values, the bit keeps 1 until software writes it.
- R6: Outside the forcing modes, a cycle with `cfg_wr_i` high loads `cfg_long_i` into the length bit, and `len_long_o` shows it in the next cycle.
- R7: A request that arrives while a pulse is running restarts the full stretch. The pulse then lasts from its start to the new request plus one full length.
- R8: Bit k of `event_i` carries code k. On each new pulse or restart, `src_code_o` takes the lowest code among the requests of that cycle. Codes: 0 power-on, 1 low supply, 2 standby overcurrent, 3 regulator short, 4 external pin, 5/6 flash entry/exit, 7/8/9 wake from standby/sleep/fail-safe, 10/11/12 watchdog early/overflow/bad code, 13 illegal mode, 14 late interrupt. Without a request the code holds its value.
- R9: A falling edge on `pin_i` from outside, while the detector is armed and the block is not driving, starts a pulse of normal length with code 4.
- R10: The line's own low level during a pulse driven by the block does not start a new pulse and does not change `src_code_o`.
- R11: After the block releases the line, the detector arms only once `pin_i` has read high on two consecutive clock edges. A fall after a single high sample is ignored, and a fall after two high samples starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| event_i | input | 15 | Single-cycle reset request strobes, bit k = code k |
| mode_i | input | 3 | Operating mode, 4 = restart, 5 = fail-safe force the long length |
| cfg_wr_i | input | 1 | Write strobe for the length-control bit |
| cfg_long_i | input | 1 | Value written: 1 long, 0 short |
| pin_i | input | 1 | Sampled level of the reset line |
| pin_drive_o | output | 1 | 1 pulls the open-drain reset line low |
| src_code_o | output | 4 | Code of the event that caused the latest reset |
| len_long_o | output | 1 | Effective length-control bit |

## Verification
The bench measures every pulse to the exact cycle. A design that starts the prescaler off-phase, or that does not restart the count on a retrigger, is one tick or one offset off. It applies several requests in the same cycle and also checks the lowest-code rule across pulses, which catches an encoder that favours the highest bit or a code register that follows the last event instead of the winner. It holds a software write of 0 against the forcing modes; a design that lets the write through gives a short pulse. After the block releases the line, the bench pulls it low again after one and then after two high samples. A detector that is never masked re-triggers on its own pulse, and one that arms too early re-triggers on the single sample.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int SRC_CNT = 15;
    localparam int CODE_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        SRC_POWER_ON      = 4'd0,
        SRC_SUPPLY_LOW    = 4'd1,
        SRC_STBY_OVERCUR  = 4'd2,
        SRC_REG_SHORT     = 4'd3,
        SRC_EXT_PIN       = 4'd4,
        SRC_FLASH_ENTER   = 4'd5,
        SRC_FLASH_EXIT    = 4'd6,
        SRC_WAKE_STBY     = 4'd7,
        SRC_WAKE_SLEEP    = 4'd8,
        SRC_WAKE_FAILSAFE = 4'd9,
        SRC_WD_EARLY      = 4'd10,
        SRC_WD_OVERFLOW   = 4'd11,
        SRC_WD_BADCODE    = 4'd12,
        SRC_BAD_MODE      = 4'd13,
        SRC_IRQ_LATE      = 4'd14
    } src_code_e;

    typedef enum logic [2:0] {
        MODE_NORMAL   = 3'd0,
        MODE_STANDBY  = 3'd1,
        MODE_SLEEP    = 3'd2,
        MODE_FLASH    = 3'd3,
        MODE_RESTART  = 3'd4,
        MODE_FAILSAFE = 3'd5
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_ASSERT  = 2'd0,
        ST_RELEASE = 2'd1,
        ST_IDLE    = 2'd2
    } rst_state_e;

endpackage

// File: rtl/rsp_prescaler.sv
module rsp_prescaler #(
    parameter int CYC_PER_TICK = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PRE_W = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_TICK - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (clear_i) begin
            pre_q <= '0;
        end else if (run_i) begin
            if (pre_q == PRE_LAST) pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = run_i && !clear_i && (pre_q == PRE_LAST);

    AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_q <= PRE_LAST); // R3
endmodule

// File: rtl/rsp_src_priority.sv
module rsp_src_priority
    import rsp_pkg::*;
#(
    parameter int NUM_SRC = SRC_CNT
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [CODE_W-1:0]  code_o
);
    always_comb begin
        code_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = CODE_W'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/rsp_len_cfg.sv
module rsp_len_cfg
    import rsp_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  op_mode_e mode_i,
    input  logic     wr_i,
    input  logic     val_i,
    output logic     long_o
);
    logic long_q;
    logic forced;

    assign forced = (mode_i == MODE_RESTART) || (mode_i == MODE_FAILSAFE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     long_q <= 1'b0;
        else if (forced) long_q <= 1'b1;
        else if (wr_i)   long_q <= val_i;
    end

    assign long_o = long_q;

    AST_FORCE_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_i == MODE_RESTART) || (mode_i == MODE_FAILSAFE)) |=> long_o); // R5
    AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (mode_i != MODE_RESTART) && (mode_i != MODE_FAILSAFE)) |=> (long_o == $past(val_i))); // R6
endmodule

// File: rtl/rsp_pin_watch.sv
module rsp_pin_watch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic drive_i,
    output logic pin_high_o,
    output logic edge_o
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       seen_high_q;
    logic       armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q      <= 2'b00;
            prev_q      <= 1'b0;
            seen_high_q <= 1'b0;
            armed_q     <= 1'b0;
        end else begin
            sync_q      <= {sync_q[0], pin_i};
            prev_q      <= sync_q[1];
            seen_high_q <= sync_q[1];
            if (drive_i)                      armed_q <= 1'b0;
            else if (sync_q[1] && seen_high_q) armed_q <= 1'b1;
        end
    end

    assign pin_high_o = sync_q[1];
    assign edge_o     = armed_q && !drive_i && prev_q && !sync_q[1];

    AST_NO_SELF_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |-> (!drive_i && !$past(drive_i))); // R10
    AST_EDGE_AFTER_TWO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(armed_q) |-> ($past(sync_q[1]) && $past(seen_high_q))); // R11
endmodule

// File: rtl/rst_pulse_stretcher.sv
module rst_pulse_stretcher
    import rsp_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 100_000_000,
    parameter int TICK_FREQ_HZ = 1000,
    parameter int SHORT_TICKS  = 1,
    parameter int LONG_TICKS   = 20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [SRC_CNT-1:0] event_i,
    input  logic [2:0]         mode_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_long_i,
    input  logic               pin_i,
    output logic               pin_drive_o,
    output logic [CODE_W-1:0]  src_code_o,
    output logic               len_long_o
);
    localparam int CYC_PER_TICK = CLK_FREQ_HZ / TICK_FREQ_HZ;
    localparam int TCNT_W       = $clog2(LONG_TICKS + 1);
    localparam logic [TCNT_W-1:0] T_SHORT = TCNT_W'(SHORT_TICKS);
    localparam logic [TCNT_W-1:0] T_LONG  = TCNT_W'(LONG_TICKS);

    rst_state_e         state_q, state_d;
    logic [TCNT_W-1:0]  ticks_q;
    logic [CODE_W-1:0]  code_q;
    logic [SRC_CNT-1:0] req_vec;
    logic               start;
    logic [CODE_W-1:0]  win_code;
    logic               tick;
    logic               ext_edge;
    logic               pin_high;
    logic               long_sel;
    logic               drive;

    rsp_pin_watch u_pin (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .drive_i    (drive),
        .pin_high_o (pin_high),
        .edge_o     (ext_edge)
    );

    always_comb begin
        req_vec              = event_i;
        req_vec[SRC_EXT_PIN] = event_i[SRC_EXT_PIN] | ext_edge;
    end

    rsp_src_priority #(.NUM_SRC(SRC_CNT)) u_prio (
        .req_i  (req_vec),
        .any_o  (start),
        .code_o (win_code)
    );

    rsp_len_cfg u_len (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (op_mode_e'(mode_i)),
        .wr_i   (cfg_wr_i),
        .val_i  (cfg_long_i),
        .long_o (long_sel)
    );

    rsp_prescaler #(.CYC_PER_TICK(CYC_PER_TICK)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start),
        .run_i   (state_q == ST_ASSERT),
        .tick_o  (tick)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ASSERT;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ASSERT;
        end else begin
            unique case (state_q)
                ST_ASSERT:  if (tick && ticks_q == TCNT_W'(1)) state_d = ST_RELEASE;
                ST_RELEASE: if (pin_high) state_d = ST_IDLE;
                ST_IDLE:    state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // stretch counter and source capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ticks_q <= T_SHORT;
            code_q  <= SRC_POWER_ON;
        end else if (start) begin
            ticks_q <= long_sel ? T_LONG : T_SHORT;
            code_q  <= win_code;
        end else if (state_q == ST_ASSERT && tick) begin
            ticks_q <= ticks_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ASSERT:  drive = 1'b1;
            ST_RELEASE: drive = 1'b0;
            ST_IDLE:    drive = 1'b0;
            default:    drive = 1'b0;
        endcase
    end

    assign pin_drive_o = drive;
    assign src_code_o  = code_q;
    assign len_long_o  = long_sel;

    AST_EVENT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i != '0) |=> pin_drive_o); // R2
    AST_TICKS_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_q <= T_LONG); // R4
    AST_CODE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((event_i == '0) && !ext_edge) |=> $stable(src_code_o)); // R8
    AST_RESTART_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((event_i != '0) && !len_long_o) |=> (ticks_q == T_SHORT)); // R7
endmodule

// File: tb/rst_pulse_stretcher_bench.sv
module rst_pulse_stretcher_bench;
    localparam int CLKF  = 16000;
    localparam int TICKF = 1000;
    localparam int CPT   = CLKF / TICKF;
    localparam int SHORT = 1;
    localparam int LONG  = 20;
    localparam int SLEN  = SHORT * CPT;
    localparam int LLEN  = LONG * CPT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] event_i = '0;
    logic [2:0]  mode = 3'd0;
    logic        cfg_wr = 1'b0;
    logic        cfg_long = 1'b0;
    logic        ext_pull = 1'b0;
    logic        pin;
    logic        drive;
    logic [3:0]  code;
    logic        len_long;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign pin = ~(drive | ext_pull);

    rst_pulse_stretcher #(
        .CLK_FREQ_HZ(CLKF), .TICK_FREQ_HZ(TICKF),
        .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)
    ) u_rst_pulse_stretcher (
        .clk_i(clk), .rst_ni(rst_n), .event_i(event_i), .mode_i(mode),
        .cfg_wr_i(cfg_wr), .cfg_long_i(cfg_long), .pin_i(pin),
        .pin_drive_o(drive), .src_code_o(code), .len_long_o(len_long)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (drive === 1'b1 && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic strobe(input logic [14:0] v);
        @(negedge clk);
        event_i = v;
        @(negedge clk);
        event_i = '0;
    endtask

    task automatic quiet_check(input int cyc, input int exp_code, input string req);
        int hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (drive !== 1'b0) hits++;
        end
        chk(hits == 0, req, hits, 0);
        chk(code == exp_code[3:0], req, code, exp_code);
    endtask

    task automatic t_power_on();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        chk(code == 4'd0, "R1 code", code, 0);
        chk(len_long == 1'b0, "R1 len", len_long, 0);
        measure(n);
        chk(n == SLEN, "R1 length", n, SLEN);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_short();
        int n;
        strobe(15'h0002);
        chk(drive == 1'b1, "R2 drive", drive, 1);
        measure(n);
        chk(n == SLEN, "R3 short length", n, SLEN);
        chk(code == 4'd1, "R3 code", code, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_priority();
        int n;
        strobe(15'h2880);
        measure(n);
        chk(code == 4'd7, "R8 lowest wins", code, 7);
        repeat (10) @(negedge clk);
        strobe(15'h4004);
        measure(n);
        chk(code == 4'd2, "R8 lowest wins 2", code, 2);
        repeat (20) @(negedge clk);
        chk(code == 4'd2, "R8 hold", code, 2);
    endtask

    task automatic t_cfg_long();
        int n;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_long = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(len_long == 1'b1, "R6 write", len_long, 1);
        strobe(15'h0400);
        measure(n);
        chk(n == LLEN, "R4 long length", n, LLEN);
        chk(code == 4'd10, "R4 code", code, 10);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_long = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(len_long == 1'b0, "R6 clear", len_long, 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_force();
        int n;
        @(negedge clk);
        mode = 3'd4; cfg_wr = 1'b1; cfg_long = 1'b0;
        repeat (3) @(negedge clk);
        cfg_wr = 1'b0;
        chk(len_long == 1'b1, "R5 restart forces", len_long, 1);
        strobe(15'h2000);
        measure(n);
        chk(n == LLEN, "R5 forced length", n, LLEN);
        mode = 3'd0;
        @(negedge clk);
        chk(len_long == 1'b1, "R5 sticky", len_long, 1);
        cfg_wr = 1'b1; cfg_long = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        mode = 3'd5;
        @(negedge clk);
        chk(len_long == 1'b1, "R5 failsafe forces", len_long, 1);
        mode = 3'd0; cfg_wr = 1'b1; cfg_long = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(len_long == 1'b0, "R6 after force", len_long, 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_retrigger();
        int n = 0;
        strobe(15'h0001);
        while (drive === 1'b1 && n < 2000) begin
            n++;
            event_i = (n == 5) ? 15'h1000 : 15'h0000;
            @(negedge clk);
        end
        event_i = '0;
        chk(n == 5 + SLEN, "R7 restart length", n, 5 + SLEN);
        chk(code == 4'd12, "R7 code", code, 12);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_external();
        int n;
        int w = 0;
        @(negedge clk);
        ext_pull = 1'b1;
        while (drive !== 1'b1 && w < 20) begin
            @(negedge clk);
            w++;
        end
        ext_pull = 1'b0;
        measure(n);
        chk(n == SLEN, "R9 external length", n, SLEN);
        chk(code == 4'd4, "R9 code", code, 4);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_mask();
        int n;
        strobe(15'h0200);
        measure(n);
        quiet_check(30, 9, "R10 own low masked");
    endtask

    task automatic t_rearm();
        int n;
        int w = 0;
        strobe(15'h0008);
        measure(n);
        @(negedge clk);
        ext_pull = 1'b1;
        repeat (6) @(negedge clk);
        ext_pull = 1'b0;
        quiet_check(10, 3, "R11 one high sample");
        strobe(15'h0008);
        measure(n);
        repeat (2) @(negedge clk);
        ext_pull = 1'b1;
        while (drive !== 1'b1 && w < 20) begin
            @(negedge clk);
            w++;
        end
        ext_pull = 1'b0;
        chk(drive == 1'b1, "R11 two high samples", drive, 1);
        chk(code == 4'd4, "R11 code", code, 4);
        measure(n);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_on();
        t_short();
        t_priority();
        t_cfg_long();
        t_force();
        t_retrigger();
        t_external();
        t_mask();
        t_rearm();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule